// File: doc/BRIEF.md
# Reference-Gated Clock Frequency Meter

This block measures the frequency of a clock by counting its rising edges while a gate is open for a programmed number of reference-clock cycles. The gate is generated in the reference domain. It crosses into the measured-clock domain through a two-flop synchronizer. There it starts a fresh count and later freezes it. The frozen count comes back to the reference domain through a toggle request/acknowledge handshake. Each returned value carries a flag that says whether the gate was still open when the value was captured.

The control side works by commands. A clear command aborts any measurement and empties the result. A start command, which may load a new window length in the same beat, opens a new measurement. When the window has closed and a final count has come back, `done_o` rises. The block keeps fetching the count. When two successive fetched values are equal, `stable_o` rises. If they differ, the result is still busy. An optional registered stage turns the count into kilohertz using the reference frequency given as a parameter.

Top module: `fm_freq_meter`

## Requirements
- R1: After reset, `count_o`, `done_o`, `stable_o` and `khz_o` are all zero, and the loaded window is `DEF_WIN` reference cycles.
- R2: After a start, the gate stays open for exactly the window length W in reference cycles. The final count differs from W x f_meas / f_ref by at less than one count, in either direction.
- R3: The count saturates at all-ones (2^CNT_W - 1) and does not wrap.
- R4: A start clears `done_o` on the next cycle. `done_o` rises only after the window has closed and a final count has been transferred, so never earlier than W reference cycles after the start. It stays high until the next start or clear.
- R5: `stable_o` rises only while `done_o` is high, and only after a second final reading equal to the first has been transferred. While it is high and no command arrives, `count_o` does not change.
- R6: When HAS_KHZ is 1, while `stable_o` is high, `khz_o` equals floor(count_o x REF_KHZ / W), where W is the window used for that measurement. The value is registered one reference cycle behind the count.
- R7: A command with `cmd_clear` = 1 aborts any measurement. On the next cycle `count_o` is 0 and `done_o` and `stable_o` are low. The block then stays idle. Clear takes priority over `cmd_enable` and `cmd_wr_en` given in the same command.
- R8: A command with `cmd_wr_en` = 1 and a non-zero `cmd_window` loads the window. A load of zero is ignored and the previous window is kept. A start without `cmd_wr_en` reuses the loaded window.
- R9: While a measurement is in progress (`done_o` low after a start), `cmd_enable` and `cmd_wr_en` are ignored. The running window and the loaded window stay unchanged.
- R10: A command carrying both `cmd_enable` and `cmd_wr_en` starts a measurement that uses the window loaded by that same command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; all control and outputs live here |
| meas_clk | input | 1 | Clock whose frequency is measured |
| rst_n | input | 1 | Synchronous active-low reset (reference domain; resynchronized for the measured domain) |
| cmd_valid | input | 1 | Command strobe, one reference cycle |
| cmd_clear | input | 1 | Command field: abort and empty the result |
| cmd_enable | input | 1 | Command field: start a measurement |
| cmd_wr_en | input | 1 | Command field: load `cmd_window` |
| cmd_window | input | WIN_W | Window length in reference cycles (zero ignored) |
| count_o | output | CNT_W | Final measured-clock edge count |
| done_o | output | 1 | Window closed and final count delivered |
| stable_o | output | 1 | Two successive readings matched |
| khz_o | output | KHZ_W | Frequency in kHz (zero when HAS_KHZ is 0) |

## Verification
The measured clock is swept over five periods, from faster than the reference to slower than it. For each period, window lengths from 3 to 255 are run, so the count is compared against its arithmetic bound, both at short windows where synchronizer quantisation dominates and at long windows where the counter saturates. Directed command patterns then check the following: the default window after reset, a zero-length load, a start and a load issued mid-measurement, and a clear with and without a start in the same beat. Each of these leaves a different trace in the final count or in the kHz value, depending on which window was actually used.

// File: rtl/fm_pkg.sv
// Package: shared types for the frequency meter.
// Assumes: nothing beyond IEEE 1800-2017.
package fm_pkg;

    // Reference-domain sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARM   = 3'd1,
        ST_RUN   = 3'd2,
        ST_FETCH = 3'd3,
        ST_DONE  = 3'd4
    } fm_state_e;

endpackage

// File: rtl/fm_sync_bit.sv
// Module: multi-flop synchronizer for a single level signal.
// Assumes: d_a is a level that holds for longer than STAGES destination
// cycles; rst_n is synchronous to clk (tie high for a reset synchronizer).
module fm_sync_bit #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_a,
    output logic q
);

    logic [STAGES-1:0] pipe;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-2:0], d_a};
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/fm_meas_side.sv
// Module: measured-clock domain of the frequency meter.
// Synchronizes the gate and counts edges while it is open. A new count
// starts at every rising edge of the gate and saturates at all-ones. On
// each toggle of the request it captures the count, together with the
// current gate level, and toggles the acknowledge.
// Assumes: gate_a and req_a are reference-domain registers; the gate stays
// open for at least two measured-clock cycles.
module fm_meas_side #(
    parameter int CNT_W = 16
) (
    input  logic             meas_clk,
    input  logic             m_rst_n,
    input  logic             gate_a,
    input  logic             req_a,
    output logic [CNT_W-1:0] hold_cnt_o,
    output logic             hold_run_o,
    output logic             ack_o
);

    logic             gate_s;
    logic             gate_d;
    logic             req_s;
    logic             req_d;
    logic [CNT_W-1:0] cnt;

    fm_sync_bit #(.STAGES(2)) i_gate_sync (
        .clk   (meas_clk),
        .rst_n (m_rst_n),
        .d_a   (gate_a),
        .q     (gate_s)
    );

    fm_sync_bit #(.STAGES(2)) i_req_sync (
        .clk   (meas_clk),
        .rst_n (m_rst_n),
        .d_a   (req_a),
        .q     (req_s)
    );

    // Edge counter: restart on gate rise, saturating count while open.
    always_ff @(posedge meas_clk) begin
        if (!m_rst_n) begin
            cnt    <= '0;
            gate_d <= 1'b0;
        end else begin
            gate_d <= gate_s;
            if (gate_s && !gate_d) begin
                cnt <= CNT_W'(1);
            end else if (gate_s && (cnt != '1)) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Handshake responder: snapshot count and gate level on each request.
    always_ff @(posedge meas_clk) begin
        if (!m_rst_n) begin
            req_d      <= 1'b0;
            hold_cnt_o <= '0;
            hold_run_o <= 1'b0;
            ack_o      <= 1'b0;
        end else begin
            req_d <= req_s;
            if (req_s != req_d) begin
                hold_cnt_o <= cnt;
                hold_run_o <= gate_s;
                ack_o      <= ~ack_o;
            end
        end
    end

    AST_SAT_HOLD: assert property (@(posedge meas_clk) disable iff (!m_rst_n)
        (cnt == '1 && gate_s && gate_d) |=> (cnt == '1)); // R3

    AST_FROZEN_WHEN_SHUT: assert property (@(posedge meas_clk) disable iff (!m_rst_n)
        (!gate_s) |=> $stable(cnt)); // R2

endmodule

// File: rtl/fm_ref_ctrl.sv
// Module: reference-domain sequencer of the frequency meter.
// Decodes commands, opens the gate for the window length, then fetches the
// frozen count through a toggle handshake. It repeats the fetch until two
// final readings agree.
// Assumes: hold_cnt_a/hold_run_a are stable whenever the synchronized
// acknowledge changes (they are written together with the acknowledge).
module fm_ref_ctrl
    import fm_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int WIN_W   = 8,
    parameter int DEF_WIN = 100
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_clear,
    input  logic             cmd_enable,
    input  logic             cmd_wr_en,
    input  logic [WIN_W-1:0] cmd_window,
    input  logic             ack_a,
    input  logic [CNT_W-1:0] hold_cnt_a,
    input  logic             hold_run_a,
    output logic             gate_o,
    output logic             req_o,
    output logic [CNT_W-1:0] count_o,
    output logic [WIN_W-1:0] run_win_o,
    output logic             done_o,
    output logic             stable_o
);

    fm_state_e        st;
    logic [WIN_W-1:0] win_q;
    logic [WIN_W-1:0] run_win_q;
    logic [WIN_W-1:0] win_cnt;
    logic [WIN_W-1:0] win_nx;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] rd_q;
    logic             gate_q;
    logic             req_q;
    logic             ack_s;
    logic             ack_d;
    logic             have_first;
    logic             done_q;
    logic             stable_q;
    logic             pending;
    logic             arrive;
    logic             idle_like;
    logic             clear_cmd;
    logic             load_cmd;
    logic             start_cmd;

    fm_sync_bit #(.STAGES(2)) i_ack_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d_a   (ack_a),
        .q     (ack_s)
    );

    // Command decode and handshake status.
    always_comb begin
        pending   = req_q ^ ack_s;
        arrive    = ack_s ^ ack_d;
        idle_like = (st == ST_IDLE) || (st == ST_DONE);
        clear_cmd = cmd_valid && cmd_clear;
        load_cmd  = cmd_valid && !cmd_clear && cmd_wr_en && idle_like
                    && (cmd_window != '0);
        start_cmd = cmd_valid && !cmd_clear && cmd_enable && idle_like;
        win_nx    = load_cmd ? cmd_window : win_q;
    end

    // Sequencer: commands, gate timing, count fetch and settle check.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            win_q      <= WIN_W'(DEF_WIN);
            run_win_q  <= WIN_W'(DEF_WIN);
            win_cnt    <= '0;
            count_q    <= '0;
            rd_q       <= '0;
            gate_q     <= 1'b0;
            req_q      <= 1'b0;
            ack_d      <= 1'b0;
            have_first <= 1'b0;
            done_q     <= 1'b0;
            stable_q   <= 1'b0;
        end else begin
            ack_d <= ack_s;
            win_q <= win_nx;
            if (clear_cmd) begin
                st         <= ST_IDLE;
                gate_q     <= 1'b0;
                count_q    <= '0;
                done_q     <= 1'b0;
                stable_q   <= 1'b0;
                have_first <= 1'b0;
            end else if (start_cmd) begin
                st         <= ST_ARM;
                run_win_q  <= win_nx;
                count_q    <= '0;
                done_q     <= 1'b0;
                stable_q   <= 1'b0;
                have_first <= 1'b0;
            end else begin
                case (st)
                    ST_ARM: begin
                        if (!pending) begin
                            gate_q  <= 1'b1;
                            win_cnt <= run_win_q;
                            st      <= ST_RUN;
                        end
                    end
                    ST_RUN: begin
                        if (win_cnt == WIN_W'(1)) begin
                            gate_q <= 1'b0;
                            st     <= ST_FETCH;
                        end else begin
                            win_cnt <= win_cnt - 1'b1;
                        end
                    end
                    ST_FETCH: begin
                        if (arrive) begin
                            if (!hold_run_a) begin
                                if (!have_first) begin
                                    rd_q       <= hold_cnt_a;
                                    count_q    <= hold_cnt_a;
                                    done_q     <= 1'b1;
                                    have_first <= 1'b1;
                                end else if (hold_cnt_a == rd_q) begin
                                    stable_q <= 1'b1;
                                    st       <= ST_DONE;
                                end else begin
                                    rd_q    <= hold_cnt_a;
                                    count_q <= hold_cnt_a;
                                end
                            end
                        end else if (!pending) begin
                            req_q <= ~req_q;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign gate_o    = gate_q;
    assign req_o     = req_q;
    assign count_o   = count_q;
    assign run_win_o = run_win_q;
    assign done_o    = done_q;
    assign stable_o  = stable_q;

    AST_STABLE_NEEDS_DONE: assert property (@(posedge ref_clk) disable iff (!rst_n)
        stable_q |-> done_q); // R5

    AST_STABLE_HOLDS: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (stable_q && !cmd_valid) |=> (stable_q && $stable(count_q))); // R5

    AST_DONE_GATE_SHUT: assert property (@(posedge ref_clk) disable iff (!rst_n)
        done_q |-> !gate_q); // R4

    AST_CLEAR_EMPTIES: assert property (@(posedge ref_clk) disable iff (!rst_n)
        clear_cmd |=> (count_q == '0 && !done_q && !stable_q && !gate_q)); // R7

    AST_WIN_NONZERO: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (win_q != '0 && run_win_q != '0)); // R8

    AST_BUSY_IGNORES_START: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (cmd_valid && !cmd_clear && st == ST_RUN) |=> (st != ST_ARM && $stable(run_win_q))); // R9

endmodule

// File: rtl/fm_khz_stage.sv
// Module: optional registered conversion of the edge count to kHz.
// Computes floor(count * REF_KHZ / window) into a register.
// Assumes: win_i is never zero (the sequencer rejects zero loads).
module fm_khz_stage #(
    parameter int CNT_W   = 16,
    parameter int WIN_W   = 8,
    parameter int REF_KHZ = 12000,
    parameter bit HAS_KHZ = 1'b1,
    parameter int KHZ_W   = 30
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic [WIN_W-1:0] win_i,
    output logic [KHZ_W-1:0] khz_o
);

    generate
        if (HAS_KHZ) begin : g_conv
            logic [KHZ_W-1:0] prod;
            logic [KHZ_W-1:0] khz_q;

            // Scale the count by the reference frequency.
            always_comb begin
                prod = KHZ_W'(count_i) * KHZ_W'(REF_KHZ);
            end

            // Register the quotient by the window length.
            always_ff @(posedge ref_clk) begin
                if (!rst_n) begin
                    khz_q <= '0;
                end else begin
                    khz_q <= prod / KHZ_W'(win_i);
                end
            end

            assign khz_o = khz_q;
        end else begin : g_noconv
            logic unused_in;
            assign unused_in = ^{ref_clk, rst_n, count_i, win_i};
            assign khz_o = '0;
        end
    endgenerate

endmodule

// File: rtl/fm_freq_meter.sv
// Module: top of the reference-gated clock frequency meter.
// Joins the reference-domain sequencer, the measured-domain counter, a
// reset synchronizer for the measured domain and the optional kHz stage.
// Assumes: rst_n is held low for at least three cycles of both clocks, and
// the first command comes at least three measured-clock cycles after release.
module fm_freq_meter #(
    parameter int CNT_W   = 16,
    parameter int WIN_W   = 8,
    parameter int DEF_WIN = 100,
    parameter int REF_KHZ = 12000,
    parameter bit HAS_KHZ = 1'b1,
    localparam int KHZ_W  = CNT_W + $clog2(REF_KHZ + 1)
) (
    input  logic             ref_clk,
    input  logic             meas_clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_clear,
    input  logic             cmd_enable,
    input  logic             cmd_wr_en,
    input  logic [WIN_W-1:0] cmd_window,
    output logic [CNT_W-1:0] count_o,
    output logic             done_o,
    output logic             stable_o,
    output logic [KHZ_W-1:0] khz_o
);

    logic             m_rst_n;
    logic             gate;
    logic             req;
    logic             ack;
    logic [CNT_W-1:0] hold_cnt;
    logic             hold_run;
    logic [WIN_W-1:0] run_win;

    fm_sync_bit #(.STAGES(2)) i_meas_rst_sync (
        .clk   (meas_clk),
        .rst_n (1'b1),
        .d_a   (rst_n),
        .q     (m_rst_n)
    );

    fm_ref_ctrl #(
        .CNT_W   (CNT_W),
        .WIN_W   (WIN_W),
        .DEF_WIN (DEF_WIN)
    ) i_ref_ctrl (
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_clear  (cmd_clear),
        .cmd_enable (cmd_enable),
        .cmd_wr_en  (cmd_wr_en),
        .cmd_window (cmd_window),
        .ack_a      (ack),
        .hold_cnt_a (hold_cnt),
        .hold_run_a (hold_run),
        .gate_o     (gate),
        .req_o      (req),
        .count_o    (count_o),
        .run_win_o  (run_win),
        .done_o     (done_o),
        .stable_o   (stable_o)
    );

    fm_meas_side #(.CNT_W(CNT_W)) i_meas_side (
        .meas_clk   (meas_clk),
        .m_rst_n    (m_rst_n),
        .gate_a     (gate),
        .req_a      (req),
        .hold_cnt_o (hold_cnt),
        .hold_run_o (hold_run),
        .ack_o      (ack)
    );

    fm_khz_stage #(
        .CNT_W   (CNT_W),
        .WIN_W   (WIN_W),
        .REF_KHZ (REF_KHZ),
        .HAS_KHZ (HAS_KHZ),
        .KHZ_W   (KHZ_W)
    ) i_khz_stage (
        .ref_clk (ref_clk),
        .rst_n   (rst_n),
        .count_i (count_o),
        .win_i   (run_win),
        .khz_o   (khz_o)
    );

endmodule

// File: tb/test_fm_freq_meter.sv
// Bench: sweeps measured-clock periods and window lengths, then runs
// directed command sequences. Expected values come from period arithmetic.
module test_fm_freq_meter;

    localparam int REF_PERIOD = 10000;
    localparam int CNT_W      = 10;
    localparam int WIN_W      = 8;
    localparam int REF_KHZ    = 100000;
    localparam int KHZ_W      = CNT_W + $clog2(REF_KHZ + 1);
    localparam longint SAT    = 1023;

    logic             ref_clk = 1'b0;
    logic             meas_clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic             cmd_clear = 1'b0;
    logic             cmd_enable = 1'b0;
    logic             cmd_wr_en = 1'b0;
    logic [WIN_W-1:0] cmd_window = '0;
    logic [CNT_W-1:0] count_o;
    logic             done_o;
    logic             stable_o;
    logic [KHZ_W-1:0] khz_o;

    int meas_half = 1650;
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    fm_freq_meter #(
        .CNT_W   (CNT_W),
        .WIN_W   (WIN_W),
        .DEF_WIN (100),
        .REF_KHZ (REF_KHZ),
        .HAS_KHZ (1'b1)
    ) i_fm_freq_meter (
        .ref_clk    (ref_clk),
        .meas_clk   (meas_clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_clear  (cmd_clear),
        .cmd_enable (cmd_enable),
        .cmd_wr_en  (cmd_wr_en),
        .cmd_window (cmd_window),
        .count_o    (count_o),
        .done_o     (done_o),
        .stable_o   (stable_o),
        .khz_o      (khz_o)
    );

    always #(REF_PERIOD / 2) ref_clk = ~ref_clk;

    initial begin
        #1234;
        forever #(meas_half) meas_clk = ~meas_clk;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic send(input bit clr, input bit en, input bit we, input int w);
        @(negedge ref_clk);
        cmd_valid  = 1'b1;
        cmd_clear  = clr;
        cmd_enable = en;
        cmd_wr_en  = we;
        cmd_window = WIN_W'(w);
        @(negedge ref_clk);
        cmd_valid  = 1'b0;
        cmd_clear  = 1'b0;
        cmd_enable = 1'b0;
        cmd_wr_en  = 1'b0;
    endtask

    // Wait for done and stable, then check count (R2/R3) and kHz (R6).
    task automatic finish(input int ew, input int mincyc);
        int cyc = 1;
        longint tr = longint'(ew) * REF_PERIOD;
        longint tm = 2 * longint'(meas_half);
        longint c;
        while (!done_o && cyc < 4000) begin
            @(negedge ref_clk);
            cyc++;
        end
        check(done_o == 1'b1, "R4 done after window", done_o, 1);
        check(cyc >= mincyc, "R4 done not before window closes", cyc, mincyc);
        check(stable_o == 1'b0, "R5 stable lags done", stable_o, 0);
        cyc = 0;
        while (!stable_o && cyc < 4000) begin
            @(negedge ref_clk);
            cyc++;
        end
        check(stable_o && done_o, "R5 stable with done", stable_o, 1);
        c = longint'(count_o);
        if (tr - tm >= SAT * tm) begin
            check(c == SAT, "R3 saturation", c, SAT);
        end else begin
            check((c * tm >= tr - tm) && (c * tm <= tr + tm), "R2 count bound", c, tr / tm);
        end
        repeat (3) @(negedge ref_clk);
        check(longint'(khz_o) == (c * REF_KHZ) / ew, "R6 khz", longint'(khz_o), (c * REF_KHZ) / ew);
        check(stable_o && longint'(count_o) == c, "R5 count holds", longint'(count_o), c);
    endtask

    task automatic measure(input int w, input bit we, input int ew);
        send(1'b0, 1'b1, we, w);
        check(done_o == 1'b0 && stable_o == 1'b0, "R4 start clears done", done_o, 0);
        finish(ew, ew);
    endtask

    initial begin
        int wins [10] = '{3, 4, 7, 12, 25, 50, 99, 100, 173, 255};
        int halves [5] = '{1650, 3550, 1450, 6850, 850};
        repeat (10) @(negedge ref_clk);
        rst_n = 1'b1;
        repeat (10) @(negedge ref_clk);

        // R1: reset state
        check(count_o == '0, "R1 count", count_o, 0);
        check(done_o == 1'b0, "R1 done", done_o, 0);
        check(stable_o == 1'b0, "R1 stable", stable_o, 0);
        check(khz_o == '0, "R1 khz", khz_o, 0);

        // R1/R8: start without load uses the default window
        measure(0, 1'b0, 100);

        // R10: start and load in one command
        measure(60, 1'b1, 60);

        // R9: start and load during a measurement are ignored
        send(1'b0, 1'b1, 1'b1, 60);
        repeat (10) @(negedge ref_clk);
        send(1'b0, 1'b1, 1'b1, 5);
        finish(60, 40);
        measure(0, 1'b0, 60);

        // R8: a zero load keeps the previous window
        measure(0, 1'b1, 60);

        // R7: clear aborts a running measurement
        send(1'b0, 1'b1, 1'b1, 200);
        repeat (20) @(negedge ref_clk);
        send(1'b1, 1'b0, 1'b0, 0);
        check(count_o == '0 && done_o == 1'b0 && stable_o == 1'b0, "R7 clear empties", done_o, 0);
        repeat (300) @(negedge ref_clk);
        check(done_o == 1'b0, "R7 stays idle after clear", done_o, 0);

        // R7: clear outranks start in the same command
        send(1'b1, 1'b1, 1'b1, 50);
        repeat (100) @(negedge ref_clk);
        check(done_o == 1'b0 && count_o == '0, "R7 clear beats start", done_o, 0);
        measure(0, 1'b0, 200);

        // R2/R3/R6/R10: sweep of measured periods and windows
        foreach (halves[p]) begin
            meas_half = halves[p];
            repeat (4) @(negedge ref_clk);
            foreach (wins[k]) begin
                measure(wins[k], 1'b1, wins[k]);
            end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(longint'(REF_PERIOD) * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule